// File: doc/BRIEF.md
# Incrementing Test Frame Checker

This block sits behind a line-side frame parser and judges every received frame against one fixed test pattern. The pattern has a fixed destination address, a fixed source address and a fixed type value, followed by a payload whose bytes fall by one from each byte to the next. Each frame must also have a length in a narrow window and must have a good CRC as reported by the parser. The CRC bytes themselves are not delivered to this block.

Bytes arrive on a valid/ready stream with start-of-frame and end-of-frame markers. The block never applies back-pressure once reset is over: `in_ready` rises on the first clock after reset is released and stays high. A byte is taken on every cycle where `in_valid` and `in_ready` are both high. The source may drop `in_valid` for any number of cycles inside a frame, and those cycles change nothing. For each finished frame the block gives a one-cycle verdict, holds the length of that frame, and keeps saturating counts of passed and failed frames.

Top module: `frame_pattern_checker`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `res_valid` and `res_pass` are 0, and `last_len`, `pass_count` and `fail_count` are 0.
- R2: `in_ready` is 1 from the first rising clock edge after reset is released and stays 1. A byte is accepted on every edge where `in_valid` and `in_ready` are both 1.
- R3: Byte position k counts from 0 at the start-of-frame byte. Positions 0..5 must be da 08 02 03 04 05, positions 6..11 must be 5a 01 02 03 04 05, and positions 12 and 13 must be ff and fe. Each position k >= 14 must be (0xfd - (k - 14)) mod 256. A mismatch at any position fails the frame.
- R4: The frame length is the number of accepted bytes from the start-of-frame byte to the end-of-frame byte, both included. A frame can pass only if its length is from 60 to 64.
- R5: `in_crc_ok` is sampled with the end-of-frame byte. A frame can pass only if it is 1 there.
- R6: On the clock edge that accepts an end-of-frame byte, `res_valid` goes to 1 for exactly one cycle with `res_pass` giving the verdict. `last_len` takes that frame's length and holds it until the next frame finishes.
- R7: `pass_count` and `fail_count` are 16 bits wide. They rise by one for each passed or failed frame, in the same cycle as `res_valid`. Each stops at all ones.
- R8: A start-of-frame byte accepted while a frame is open counts the open frame as failed: `fail_count` rises by one, with no `res_valid` for that frame. The same byte then starts a new frame at position 0.
- R9: Bytes accepted while no frame is open and without start-of-frame, including ones marked end-of-frame, are ignored. No result is given and no count changes.
- R10: A byte that carries both start-of-frame and end-of-frame is a one-byte frame and fails on length. If it also ends an open frame, `fail_count` rises by two.
- R11: Cycles with `in_valid` low inside a frame do not disturb the position count or the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Block can take a byte (always 1 out of reset) |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_crc_ok | input | 1 | Parser found the CRC good; sampled with the end-of-frame byte |
| res_valid | output | 1 | One-cycle pulse: frame verdict present |
| res_pass | output | 1 | Frame passed all checks (meaningful with `res_valid`) |
| last_len | output | 11 | Length of the most recently finished frame |
| pass_count | output | 16 | Saturating count of passed frames |
| fail_count | output | 16 | Saturating count of failed frames |

## Verification
Every result is registered once. The verdict, the length and the count steps are therefore visible after the same rising edge that takes the end-of-frame byte. The extra failure from an interrupted frame shows after the edge that takes the new start-of-frame byte. The bench drives on falling edges and checks on the next falling edge, which lies half a period after the edge that should produce the result. It also checks, one cycle later again, that `res_valid` has dropped. A second instance built with 3-bit counters is fed the same stimulus, so that saturation is reached within the run and the wide counters are compared against the same reference model.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  // Header layout: positions where each field ends (exclusive).
  localparam int DST_END = 6;
  localparam int SRC_END = 12;
  localparam int HDR_LEN = 14;

  typedef enum logic [1:0] {
    RG_DST = 2'd0,
    RG_SRC = 2'd1,
    RG_TYP = 2'd2,
    RG_PAY = 2'd3
  } region_e;

endpackage

// File: rtl/tfc_expect.sv
module tfc_expect #(
  parameter int          LEN_W     = 11,
  parameter logic [47:0] DST_ADDR  = 48'hda08_0203_0405,
  parameter logic [47:0] SRC_ADDR  = 48'h5a01_0203_0405,
  parameter logic [15:0] TYPE_VAL  = 16'hfffe,
  parameter logic [7:0]  PAY_FIRST = 8'hfd
) (
  input  logic [LEN_W-1:0]     pos_i,
  output tfc_pkg::region_e     region_o,
  output logic [7:0]           byte_o
);
  import tfc_pkg::*;

  localparam logic [LEN_W-1:0] P_DST = LEN_W'(DST_END);
  localparam logic [LEN_W-1:0] P_SRC = LEN_W'(SRC_END);
  localparam logic [LEN_W-1:0] P_HDR = LEN_W'(HDR_LEN);

  logic [LEN_W-1:0] pay_off;
  logic [7:0]       addr_byte_dst;
  logic [7:0]       addr_byte_src;

  always_comb begin
    if (pos_i < P_DST)      region_o = RG_DST;
    else if (pos_i < P_SRC) region_o = RG_SRC;
    else if (pos_i < P_HDR) region_o = RG_TYP;
    else                    region_o = RG_PAY;
  end

  // Address bytes, most significant first on the wire.
  always_comb begin
    addr_byte_dst = 8'h00;
    addr_byte_src = 8'h00;
    for (int k = 0; k < DST_END; k++) begin
      if (pos_i == LEN_W'(k)) addr_byte_dst = DST_ADDR[47-8*k -: 8];
    end
    for (int k = 0; k < SRC_END - DST_END; k++) begin
      if (pos_i == LEN_W'(k + DST_END)) addr_byte_src = SRC_ADDR[47-8*k -: 8];
    end
  end

  assign pay_off = pos_i - P_HDR;

  always_comb begin
    unique case (region_o)
      RG_DST:  byte_o = addr_byte_dst;
      RG_SRC:  byte_o = addr_byte_src;
      RG_TYP:  byte_o = (pos_i == P_SRC) ? TYPE_VAL[15:8] : TYPE_VAL[7:0];
      default: byte_o = PAY_FIRST - pay_off[7:0];
    endcase
  end

endmodule

// File: rtl/tfc_track.sv
module tfc_track #(
  parameter int          LEN_W     = 11,
  parameter int          MIN_LEN   = 60,
  parameter int          MAX_LEN   = 64,
  parameter logic [47:0] DST_ADDR  = 48'hda08_0203_0405,
  parameter logic [47:0] SRC_ADDR  = 48'h5a01_0203_0405,
  parameter logic [15:0] TYPE_VAL  = 16'hfffe,
  parameter logic [7:0]  PAY_FIRST = 8'hfd
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_ok,
  output logic             ready_o,
  output logic             abort_o,
  output logic             done_o,
  output logic             pass_o,
  output logic [LEN_W-1:0] len_o
);
  import tfc_pkg::*;

  localparam logic [LEN_W-1:0] POS_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_LO  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_HI  = LEN_W'(MAX_LEN);

  logic             rdy_q;
  logic             active_q;
  logic             bad_q;
  logic [LEN_W-1:0] idx_q;

  logic             take;
  logic             open_now;
  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] len_now;
  logic [7:0]       exp_byte;
  region_e          region;
  logic             byte_bad;
  logic             bad_all;
  logic             len_ok;

  tfc_expect #(
    .LEN_W(LEN_W), .DST_ADDR(DST_ADDR), .SRC_ADDR(SRC_ADDR),
    .TYPE_VAL(TYPE_VAL), .PAY_FIRST(PAY_FIRST)
  ) u_expect (
    .pos_i   (pos),
    .region_o(region),
    .byte_o  (exp_byte)
  );

  assign take     = in_valid & rdy_q;
  assign open_now = in_sof | active_q;
  assign pos      = in_sof ? '0 : idx_q;
  assign len_now  = (pos == POS_MAX) ? POS_MAX : pos + LEN_W'(1);
  assign byte_bad = (in_data != exp_byte);
  assign bad_all  = (in_sof ? 1'b0 : bad_q) | byte_bad;
  assign len_ok   = (len_now >= LEN_LO) && (len_now <= LEN_HI);

  assign ready_o  = rdy_q;
  assign abort_o  = take & in_sof & active_q;
  assign done_o   = take & in_eof & open_now;
  assign pass_o   = ~bad_all & len_ok & in_crc_ok;
  assign len_o    = len_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      active_q <= 1'b0;
      bad_q    <= 1'b0;
      idx_q    <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (take && open_now) begin
        active_q <= ~in_eof;
        idx_q    <= len_now;
        bad_q    <= bad_all;
      end
    end
  end

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> rdy_q);

  // R9
  stray_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_sof && !active_q) |=> !active_q);

  // R3
  hdr_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_sof) |-> (region == RG_DST));

endmodule

// File: rtl/tfc_tally.sv
module tfc_tally #(
  parameter int LEN_W   = 11,
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic             done_i,
  input  logic             pass_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             res_valid_o,
  output logic             res_pass_o,
  output logic [LEN_W-1:0] last_len_o,
  output logic [CNT_W-1:0] pass_cnt_o,
  output logic [CNT_W-1:0] fail_cnt_o
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] c,
                                               input logic [1:0] inc);
    logic [CNT_W:0] s;
    s = {1'b0, c} + (CNT_W+1)'(inc);
    return s[CNT_W] ? CMAX : s[CNT_W-1:0];
  endfunction

  logic [1:0] fail_inc;
  logic [1:0] pass_inc;

  assign fail_inc = {1'b0, abort_i} + {1'b0, done_i & ~pass_i};
  assign pass_inc = {1'b0, done_i & pass_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_pass_o  <= 1'b0;
      last_len_o  <= '0;
      pass_cnt_o  <= '0;
      fail_cnt_o  <= '0;
    end else begin
      res_valid_o <= done_i;
      res_pass_o  <= done_i & pass_i;
      if (done_i) last_len_o <= len_i;
      pass_cnt_o <= sat_add(pass_cnt_o, pass_inc);
      fail_cnt_o <= sat_add(fail_cnt_o, fail_inc);
    end
  end

  // R7
  pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && pass_i && pass_cnt_o != CMAX) |=> pass_cnt_o == $past(pass_cnt_o) + CNT_W'(1));

  // R7
  fail_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cnt_o == CMAX) |=> (fail_cnt_o == CMAX));

  // R4
  pass_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass_o |-> (last_len_o >= LEN_W'(MIN_LEN) && last_len_o <= LEN_W'(MAX_LEN)));

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !done_i) |=> !res_valid_o);

endmodule

// File: rtl/frame_pattern_checker.sv
module frame_pattern_checker #(
  parameter int          LEN_W     = 11,
  parameter int          CNT_W     = 16,
  parameter int          MIN_LEN   = 60,
  parameter int          MAX_LEN   = 64,
  parameter logic [47:0] DST_ADDR  = 48'hda08_0203_0405,
  parameter logic [47:0] SRC_ADDR  = 48'h5a01_0203_0405,
  parameter logic [15:0] TYPE_VAL  = 16'hfffe,
  parameter logic [7:0]  PAY_FIRST = 8'hfd
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_ok,
  output logic             res_valid,
  output logic             res_pass,
  output logic [LEN_W-1:0] last_len,
  output logic [CNT_W-1:0] pass_count,
  output logic [CNT_W-1:0] fail_count
);

  logic             abort_w;
  logic             done_w;
  logic             pass_w;
  logic [LEN_W-1:0] len_w;

  tfc_track #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
    .DST_ADDR(DST_ADDR), .SRC_ADDR(SRC_ADDR),
    .TYPE_VAL(TYPE_VAL), .PAY_FIRST(PAY_FIRST)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_crc_ok(in_crc_ok),
    .ready_o  (in_ready),
    .abort_o  (abort_w),
    .done_o   (done_w),
    .pass_o   (pass_w),
    .len_o    (len_w)
  );

  tfc_tally #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_i    (abort_w),
    .done_i     (done_w),
    .pass_i     (pass_w),
    .len_i      (len_w),
    .res_valid_o(res_valid),
    .res_pass_o (res_pass),
    .last_len_o (last_len),
    .pass_cnt_o (pass_count),
    .fail_cnt_o (fail_count)
  );

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !done_w) |=> !res_valid);

endmodule

// File: tb/tb_frame_pattern_checker.sv
`timescale 1ns/1ps
module tb_frame_pattern_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        in_crc_ok = 1'b0;

  logic        in_ready, res_valid, res_pass;
  logic [10:0] last_len;
  logic [15:0] pass_count, fail_count;

  logic        s_ready, s_valid, s_pass;
  logic [10:0] s_len;
  logic [2:0]  s_pass_cnt, s_fail_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int exp_pass = 0;
  int exp_fail = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  frame_pattern_checker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_crc_ok(in_crc_ok),
    .res_valid(res_valid), .res_pass(res_pass), .last_len(last_len),
    .pass_count(pass_count), .fail_count(fail_count)
  );

  frame_pattern_checker #(.CNT_W(3)) dut_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(s_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_crc_ok(in_crc_ok),
    .res_valid(s_valid), .res_pass(s_pass), .last_len(s_len),
    .pass_count(s_pass_cnt), .fail_count(s_fail_cnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] pat_byte(input int k);
    logic [7:0] dst [6] = '{8'hda, 8'h08, 8'h02, 8'h03, 8'h04, 8'h05};
    logic [7:0] src [6] = '{8'h5a, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    if (k < 6)   return dst[k];
    if (k < 12)  return src[k-6];
    if (k == 12) return 8'hff;
    if (k == 13) return 8'hfe;
    return 8'(253 - (k - 14));
  endfunction

  function automatic int sat16(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic put(input logic [7:0] d, input bit s, input bit e, input bit c);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_crc_ok = c;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_counts(input string tag);
    check(pass_count == 16'(sat16(exp_pass)), {tag, " R7 pass_count"}, pass_count, sat16(exp_pass));
    check(fail_count == 16'(sat16(exp_fail)), {tag, " R7 fail_count"}, fail_count, sat16(exp_fail));
  endtask

  // Sends one frame; bad_pos < 0 means no corruption. The verdict is checked
  // half a cycle after the edge that takes the end-of-frame byte.
  task automatic run_frame(input string tag, input int len, input int bad_pos,
                           input bit crc, input bit gaps, input bit after_open);
    bit want;
    want = (bad_pos < 0) && (len >= 60) && (len <= 64) && crc;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = pat_byte(i);
      if (i == bad_pos) b = b ^ 8'h10;
      put(b, i == 0, i == len - 1, crc);
      if (i == 0 && after_open && len > 1) begin
        exp_fail++;
        check(res_valid == 1'b0, {tag, " R8 no verdict for cut frame"}, res_valid, 0);
        check(fail_count == 16'(sat16(exp_fail)), {tag, " R8 cut frame counted"}, fail_count, sat16(exp_fail));
      end
      if (gaps && (i % 7) == 3 && i != len - 1) idle(2);
    end
    if (want) exp_pass++; else exp_fail++;
    check(res_valid == 1'b1, {tag, " R6 res_valid"}, res_valid, 1);
    check(res_pass == want, {tag, " R6 res_pass"}, res_pass, int'(want));
    check(last_len == 11'(len), {tag, " R6 last_len"}, last_len, len);
    check_counts(tag);
    idle(1);
    check(res_valid == 1'b0, {tag, " R6 pulse ends"}, res_valid, 0);
    check(last_len == 11'(len), {tag, " R6 last_len held"}, last_len, len);
  endtask

  task automatic partial(input int n);
    for (int i = 0; i < n; i++) put(pat_byte(i), i == 0, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    #1;
    check(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
    check(res_valid == 1'b0 && res_pass == 1'b0, "R1 result in reset", res_valid, 0);
    check(last_len == 0, "R1 last_len in reset", last_len, 0);
    check(pass_count == 0 && fail_count == 0, "R1 counters in reset", fail_count, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R2 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_good;
    for (int l = 60; l <= 64; l++) run_frame("R3 R4 good", l, -1, 1'b1, 1'b0, 1'b0);
    check(in_ready == 1'b1, "R2 in_ready stays high", in_ready, 1);
  endtask

  task automatic t_gaps;
    run_frame("R11 gaps", 62, -1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_length;
    run_frame("R4 short", 59, -1, 1'b1, 1'b0, 1'b0);
    run_frame("R4 long", 65, -1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_crc;
    run_frame("R5 crc bad", 61, -1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_corrupt;
    run_frame("R3 dst byte", 60, 0, 1'b1, 1'b0, 1'b0);
    run_frame("R3 src byte", 60, 8, 1'b1, 1'b0, 1'b0);
    run_frame("R3 type byte", 60, 13, 1'b1, 1'b0, 1'b0);
    run_frame("R3 payload byte", 64, 63, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_abort;
    partial(20);
    run_frame("R8 restart", 60, -1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_stray;
    put(8'hda, 1'b0, 1'b0, 1'b1);
    check(res_valid == 1'b0, "R9 stray byte", res_valid, 0);
    put(8'h08, 1'b0, 1'b0, 1'b1);
    put(8'h55, 1'b0, 1'b1, 1'b1);
    check(res_valid == 1'b0, "R9 stray eof", res_valid, 0);
    idle(1);
    check(res_valid == 1'b0, "R9 stray no verdict", res_valid, 0);
    check_counts("R9 stray");
    run_frame("R9 after stray", 63, -1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_single;
    run_frame("R10 single", 1, -1, 1'b1, 1'b0, 1'b0);
    partial(10);
    put(8'hda, 1'b1, 1'b1, 1'b1);
    exp_fail += 2;
    check(res_valid == 1'b1 && res_pass == 1'b0, "R10 single after open", res_pass, 0);
    check(last_len == 1, "R10 single length", last_len, 1);
    check_counts("R10 double fail");
    idle(1);
  endtask

  task automatic t_saturate;
    int ep, ef;
    ep = (exp_pass > 7) ? 7 : exp_pass;
    ef = (exp_fail > 7) ? 7 : exp_fail;
    check(s_pass_cnt == 3'(ep), "R7 narrow pass saturates", s_pass_cnt, ep);
    check(s_fail_cnt == 3'(ef), "R7 narrow fail saturates", s_fail_cnt, ef);
  endtask

  task automatic finish_up;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_good;
    t_gaps;
    t_length;
    t_crc;
    t_corrupt;
    t_abort;
    t_stray;
    t_single;
    run_frame("R7 extra pass", 64, -1, 1'b1, 1'b0, 1'b0);
    t_saturate;
    finish_up;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_up;
  end

endmodule